// File: doc/BRIEF.md
# Shifted-Operand Adder with Flags

This block is the add path of an integer execute stage. It takes a first operand and a second operand that passes through a shifter first, then adds the two with no carry-in. It produces a 32-bit sum and a four-bit condition code holding negative, zero, carry and overflow. Shift type and amount come from a 2-bit kind field and a 5-bit immediate. A zero immediate gets a special meaning for some kinds: a full-width right shift for the two right-shift kinds, and a one-bit rotate through the incoming carry for the rotate kind.

A flags register holds the last condition code written. It is written only when the operation asks for a flag update and the destination index is not the link index (15). When the destination index is 15, the sum is also offered as a jump target, qualified by a valid strobe, and the flags register keeps its old value. Apart from the rotate-through-carry case, the incoming carry has no effect. The carry that the shifter shifts out is never used.

Top module: `shift_add_unit`

## Requirements
- R1: `shift_kind_i` encodes 00 = logical left, 01 = logical right, 10 = arithmetic right, 11 = rotate right. A logical-left shift moves `op_b_i` left by `shift_imm_i` (0..31), so an immediate of 0 passes it through unchanged.
- R2: A logical-right shift moves `op_b_i` right by `shift_imm_i` and fills with zeros. An immediate of 0 means a shift by 32, which gives zero.
- R3: An arithmetic-right shift moves `op_b_i` right by `shift_imm_i` and fills with copies of bit 31. An immediate of 0 means a shift by 32, which gives all bits equal to bit 31.
- R4: A rotate-right with a nonzero immediate rotates `op_b_i` right by `shift_imm_i` (1..31).
- R5: A rotate-right with a zero immediate gives `{carry_i, op_b_i[31:1]}`.
- R6: `result_o` is `op_a_i` plus the shifted operand, modulo 2^32, with carry-in 0. In `nzcv_o`, bit 3 = N (result bit 31), bit 2 = Z (result is zero), bit 1 = C (unsigned carry out of the add), bit 0 = V (signed overflow of the add).
- R7: C depends only on the add. The bit the shifter shifts out never reaches C, and `carry_i` has no effect except in the R5 case.
- R8: When `set_flags_i` is 1 and `dest_idx_i` is not 15, `flags_o` takes the value of `nzcv_o` at the next rising edge of `clk_i`.
- R9: In every other cycle, including `set_flags_i` = 1 with `dest_idx_i` = 15, `flags_o` keeps its value.
- R10: `target_valid_o` is 1 exactly when `dest_idx_i` is 15. `target_o` always equals `result_o`.
- R11: While `rst_ni` is low, `flags_o` is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_a_i | input | 32 | First addend |
| op_b_i | input | 32 | Operand that is shifted before the add |
| shift_kind_i | input | 2 | Shift type code |
| shift_imm_i | input | 5 | Immediate shift amount field |
| set_flags_i | input | 1 | Request to update the flags register |
| dest_idx_i | input | 4 | Destination index; 15 marks a jump |
| carry_i | input | 1 | Current carry flag, used only by the rotate-through-carry case |
| result_o | output | 32 | Sum |
| nzcv_o | output | 4 | Condition code of this sum |
| flags_o | output | 4 | Registered condition code |
| target_o | output | 32 | Jump target, equal to the sum |
| target_valid_o | output | 1 | Jump target is valid |

## Verification
The assertions check three things on every cycle: the flags register takes the condition code when a write is enabled, and holds its value otherwise, including the index-15 case. N and Z agree with the sum. The target strobe follows the destination index, with the target equal to the sum. Shift arithmetic cannot be read from ports in a property. The bench therefore compares each sum and condition code against loop-based reference shifts, over random operands and all four kinds. It also drives directed cases: zero immediates, amounts 1 and 31, the rotate-through-carry case with carry 0 and 1, and a shift whose lost bit would give a wrong carry.

// File: rtl/shift_add_pkg.sv
package shift_add_pkg;
  typedef enum logic [1:0] {
    KIND_LSL = 2'b00,
    KIND_LSR = 2'b01,
    KIND_ASR = 2'b10,
    KIND_ROR = 2'b11
  } shift_kind_e;

  typedef enum logic [2:0] {
    OP_LSL,
    OP_LSR,
    OP_ASR,
    OP_ROR,
    OP_RRX
  } shift_op_e;
endpackage

// File: rtl/shift_add_decode.sv
module shift_add_decode
  import shift_add_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IMM_W = $clog2(DATA_W),
  localparam int unsigned AMT_W = IMM_W + 1
) (
  input  logic [1:0]       kind_i,
  input  logic [IMM_W-1:0] imm_i,
  output shift_op_e        op_o,
  output logic [AMT_W-1:0] amt_o
);
  logic imm_zero;
  assign imm_zero = (imm_i == '0);

  always_comb begin
    op_o  = OP_LSL;
    amt_o = AMT_W'(imm_i);
    unique case (shift_kind_e'(kind_i))
      KIND_LSL: op_o = OP_LSL;
      KIND_LSR: begin
        op_o = OP_LSR;
        if (imm_zero) amt_o = AMT_W'(DATA_W);
      end
      KIND_ASR: begin
        op_o = OP_ASR;
        if (imm_zero) amt_o = AMT_W'(DATA_W);
      end
      KIND_ROR: begin
        op_o = imm_zero ? OP_RRX : OP_ROR;
        if (imm_zero) amt_o = AMT_W'(1);
      end
      default: op_o = OP_LSL;
    endcase
  end
endmodule

// File: rtl/shift_add_shifter.sv
module shift_add_shifter
  import shift_add_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AMT_W = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] b_i,
  input  shift_op_e         op_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] sh_o
);
  logic [AMT_W-1:0] inv_amt;
  assign inv_amt = AMT_W'(DATA_W) - amt_i;

  // shifted-out bits are dropped; carry comes from the adder only
  always_comb begin
    unique case (op_i)
      OP_LSL:  sh_o = b_i << amt_i;
      OP_LSR:  sh_o = b_i >> amt_i;
      OP_ASR:  sh_o = DATA_W'($signed(b_i) >>> amt_i);
      OP_ROR:  sh_o = (b_i >> amt_i) | (b_i << inv_amt);
      OP_RRX:  sh_o = {carry_i, b_i[DATA_W-1:1]};
      default: sh_o = b_i;
    endcase
  end
endmodule

// File: rtl/shift_add_adder.sv
module shift_add_adder #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [3:0]        nzcv_o
);
  logic cout;
  assign {cout, sum_o} = {1'b0, a_i} + {1'b0, b_i};

  assign nzcv_o = {sum_o[DATA_W-1],
                   sum_o == '0,
                   cout,
                   (a_i[DATA_W-1] == b_i[DATA_W-1]) && (sum_o[DATA_W-1] != a_i[DATA_W-1])};
endmodule

// File: rtl/shift_add_unit.sv
module shift_add_unit
  import shift_add_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned LINK_IDX = 15,
  localparam int unsigned IMM_W = $clog2(DATA_W),
  localparam int unsigned AMT_W = IMM_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [1:0]        shift_kind_i,
  input  logic [IMM_W-1:0]  shift_imm_i,
  input  logic              set_flags_i,
  input  logic [IDX_W-1:0]  dest_idx_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic [3:0]        nzcv_o,
  output logic [3:0]        flags_o,
  output logic [DATA_W-1:0] target_o,
  output logic              target_valid_o
);
  shift_op_e         sh_op;
  logic [AMT_W-1:0]  sh_amt;
  logic [DATA_W-1:0] sh_val;
  logic              is_link;
  logic              flags_we;

  shift_add_decode #(.DATA_W(DATA_W)) u_decode (
    .kind_i (shift_kind_i),
    .imm_i  (shift_imm_i),
    .op_o   (sh_op),
    .amt_o  (sh_amt)
  );

  shift_add_shifter #(.DATA_W(DATA_W)) u_shifter (
    .b_i     (op_b_i),
    .op_i    (sh_op),
    .amt_i   (sh_amt),
    .carry_i (carry_i),
    .sh_o    (sh_val)
  );

  shift_add_adder #(.DATA_W(DATA_W)) u_adder (
    .a_i    (op_a_i),
    .b_i    (sh_val),
    .sum_o  (result_o),
    .nzcv_o (nzcv_o)
  );

  assign is_link        = (dest_idx_i == IDX_W'(LINK_IDX));
  assign flags_we       = set_flags_i && !is_link;
  assign target_o       = result_o;
  assign target_valid_o = is_link;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flags_o <= '0;
    else if (flags_we) flags_o <= nzcv_o;
  end
endmodule

// File: rtl/shift_add_unit_chk.sv
module shift_add_unit_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned LINK_IDX = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              set_flags_i,
  input logic [IDX_W-1:0]  dest_idx_i,
  input logic [DATA_W-1:0] result_o,
  input logic [3:0]        nzcv_o,
  input logic [3:0]        flags_o,
  input logic [DATA_W-1:0] target_o,
  input logic              target_valid_o
);
  assert_flags_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && dest_idx_i != IDX_W'(LINK_IDX)) |=> (flags_o == $past(nzcv_o)));

  assert_flags_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_flags_i && dest_idx_i != IDX_W'(LINK_IDX)) |=> $stable(flags_o));

  assert_n_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nzcv_o[3] == result_o[DATA_W-1]);

  assert_z_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nzcv_o[2] == (result_o == '0));

  assert_target_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    target_valid_o == (dest_idx_i == IDX_W'(LINK_IDX)));

  assert_target_value_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    target_valid_o |-> (target_o == result_o));

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_flags_R11: assert (flags_o == 4'b0000);
  end
endmodule

bind shift_add_unit shift_add_unit_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .LINK_IDX(LINK_IDX)
) u_chk (.*);

// File: tb/shift_add_unit_bench.sv
module shift_add_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [31:0] op_a_i, op_b_i;
  logic [1:0]  shift_kind_i;
  logic [4:0]  shift_imm_i;
  logic        set_flags_i;
  logic [3:0]  dest_idx_i;
  logic        carry_i;
  logic [31:0] result_o, target_o;
  logic [3:0]  nzcv_o, flags_o;
  logic        target_valid_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] exp_flags = 4'b0000;
  int unsigned seed_v;

  always #4 clk_i = ~clk_i;

  shift_add_unit u_shift_add_unit (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_shift(logic [31:0] b, logic [1:0] kind,
                                            logic [4:0] imm, logic cin);
    logic [31:0] v = b;
    int n = (imm == 0 && (kind == 2'b01 || kind == 2'b10)) ? 32 : int'(imm);
    case (kind)
      2'b00: for (int i = 0; i < n; i++) v = {v[30:0], 1'b0};
      2'b01: for (int i = 0; i < n; i++) v = {1'b0, v[31:1]};
      2'b10: for (int i = 0; i < n; i++) v = {v[31], v[31:1]};
      default: begin
        if (imm == 0) v = {cin, b[31:1]};
        else for (int i = 0; i < n; i++) v = {v[0], v[31:1]};
      end
    endcase
    return v;
  endfunction

  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [1:0] kind,
                     input logic [4:0] imm, input logic sf, input logic [3:0] dst,
                     input logic cin, input string tag);
    logic [31:0] sb;
    logic [32:0] full;
    logic [3:0]  nz;
    @(negedge clk_i);
    op_a_i = a; op_b_i = b; shift_kind_i = kind; shift_imm_i = imm;
    set_flags_i = sf; dest_idx_i = dst; carry_i = cin;
    #1;
    sb   = ref_shift(b, kind, imm, cin);
    full = {1'b0, a} + {1'b0, sb};
    nz   = {full[31], full[31:0] == 0, full[32],
            (a[31] == sb[31]) && (full[31] != a[31])};
    check({tag, " result"}, result_o, full[31:0]);
    check("R6 nzcv", {28'd0, nzcv_o}, {28'd0, nz});
    check("R10 target", {target_o[31:1], target_valid_o}, {full[31:1], dst == 4'd15});
    if (sf && dst != 4'd15) exp_flags = nz;
    @(posedge clk_i); #1;
    check((sf && dst != 4'd15) ? "R8 flags write" : "R9 flags hold",
          {28'd0, flags_o}, {28'd0, exp_flags});
  endtask

  initial begin
    seed_v = 32'h5eed_1234;
    void'($urandom(seed_v));
    rst_ni = 1'b0;
    op_a_i = '0; op_b_i = '0; shift_kind_i = '0; shift_imm_i = '0;
    set_flags_i = 1'b0; dest_idx_i = '0; carry_i = 1'b0;
    repeat (3) @(posedge clk_i);
    #1 check("R11 reset flags", {28'd0, flags_o}, 32'd0);
    set_flags_i = 1'b1;
    @(posedge clk_i); #1;
    check("R11 reset held", {28'd0, flags_o}, 32'd0);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1: pass-through and limits
    run(32'h1, 32'hdead_beef, 2'b00, 5'd0, 1, 4'd2, 1, "R1 lsl0");
    run(32'h0, 32'h0000_0003, 2'b00, 5'd31, 1, 4'd2, 0, "R1 lsl31");
    // R2 / R3: field zero means 32
    run(32'h5, 32'hffff_ffff, 2'b01, 5'd0, 1, 4'd3, 1, "R2 lsr32");
    run(32'h0, 32'h8000_0000, 2'b01, 5'd31, 1, 4'd3, 0, "R2 lsr31");
    run(32'h0, 32'h8000_0000, 2'b10, 5'd0, 1, 4'd4, 0, "R3 asr32");
    run(32'h1, 32'h8000_0000, 2'b10, 5'd0, 1, 4'd4, 0, "R3 asr32 zero-sum");
    run(32'h0, 32'h7000_0000, 2'b10, 5'd1, 1, 4'd4, 0, "R3 asr1");
    // R4 / R5
    run(32'h0, 32'h0000_0001, 2'b11, 5'd1, 1, 4'd5, 0, "R4 ror1");
    run(32'h0, 32'h8000_0001, 2'b11, 5'd31, 1, 4'd5, 0, "R4 ror31");
    run(32'h0, 32'h0000_0003, 2'b11, 5'd0, 1, 4'd5, 1, "R5 rrx c1");
    run(32'h0, 32'h0000_0003, 2'b11, 5'd0, 1, 4'd5, 0, "R5 rrx c0");
    // R7: lost shifter bit must not reach C; carry_i ignored outside rotate-through
    run(32'h0, 32'h8000_0000, 2'b00, 5'd1, 1, 4'd1, 1, "R7 lsl lost bit");
    check("R7 carry clear", {31'd0, flags_o[1]}, 32'd0);
    run(32'h0, 32'h0000_0001, 2'b01, 5'd1, 1, 4'd1, 1, "R7 lsr lost bit");
    check("R7 carry clear lsr", {31'd0, flags_o[1]}, 32'd0);
    // R6: carry and overflow
    run(32'hffff_ffff, 32'h1, 2'b00, 5'd0, 1, 4'd0, 0, "R6 carry");
    run(32'h7fff_ffff, 32'h1, 2'b00, 5'd0, 1, 4'd0, 0, "R6 overflow");
    // R9: index 15 leaves flags, R10 strobe
    run(32'h1000, 32'h4, 2'b00, 5'd2, 1, 4'd15, 0, "R10 link");
    run(32'h0, 32'h0, 2'b00, 5'd0, 0, 4'd7, 0, "R9 no request");

    for (int i = 0; i < 400; i++) begin
      logic [1:0] k = 2'($urandom);
      string t;
      t = (k == 2'b00) ? "R1 rnd" : (k == 2'b01) ? "R2 rnd" : (k == 2'b10) ? "R3 rnd" : "R4 rnd";
      run($urandom, $urandom, k, 5'($urandom), 1'($urandom),
          ($urandom_range(0, 7) == 0) ? 4'd15 : 4'($urandom), 1'($urandom), t);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule